// File: doc/BRIEF.md
# Video Test Pattern Generator

This block produces a stream of RGB test pixels, one pixel per clock and 8 bits per channel, for a parallel video output. It follows an external timing source. The data-enable, horizontal-sync and vertical-sync inputs pass through to the outputs two clocks later. A pixel value is built for every cycle in which data-enable is high. The frame width and height come in from the timing block on their own inputs and set the scale of the brightness ramps.

A 4-bit pattern code selects the content. The codes cover solid colours, vertical ramps and horizontal ramps. A full ramp always runs from 0 up to exactly 255 across the active height or width. Two options act on the final pixel. An 18-bit depth mode clears the two lowest bits of each channel. A global inversion option then complements every bit. In auto-scroll mode the code comes from a list of up to 16 entries rather than from the fixed code input, and the block moves to the next entry at each frame boundary.

Top module: `tpg_top`

## Requirements
- R1: While reset is high, and on the first cycles after it falls with idle inputs, all outputs are 0.
- R2: Pattern codes: 0 black, 1 white, 2 red, 3 green, 4 blue (each channel at 0 or 255). Codes 13 to 15 give black.
- R3: Codes 5 to 8 are vertical ramps in gray, red, green and blue. The channel level on active line y (counted from 0 after the frame boundary) is floor(y*255/(H-1)), where H is `act_height`; when H is at most 1 the level is 0.
- R4: Codes 9 to 12 are horizontal ramps in gray, red, green and blue. The level at active pixel x of a line is floor(x*255/(W-1)), where W is `act_width`; when W is at most 1 the level is 0.
- R5: With `cfg_18bit` high, bits 1:0 of every channel are 0 and bits 7:2 carry the pattern. With it low, all 8 bits carry the pattern.
- R6: With `cfg_invert` high, every RGB bit is complemented after the 18-bit mask, so the two low bits read 1 in inverted 18-bit mode.
- R7: When the output data-enable is low, all RGB outputs are 0, including when inversion is on.
- R8: `out_de`, `out_hs` and `out_vs` equal the inputs of two clocks earlier, and each RGB value lines up with its delayed data-enable.
- R9: In auto-scroll mode, entry i of the list is bits [4i+3:4i] of `cfg_scroll_list`. The entry index changes only at a frame boundary (a rising edge of `vid_vs`), where it steps by one. Repeated codes in the list are shown in list order.
- R10: At a frame boundary, the index wraps from entry `cfg_scroll_len`-1 to entry 0. A length of 0 or 1 keeps entry 0.
- R11: With auto-scroll off, the code comes from `cfg_pattern` and the list index is held at 0, so the first boundary after enabling shows entry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_de | input | 1 | Incoming data-enable |
| vid_hs | input | 1 | Incoming horizontal sync |
| vid_vs | input | 1 | Incoming vertical sync; a rising edge marks a frame boundary |
| act_width | input | DIM_W | Active pixels per line |
| act_height | input | DIM_W | Active lines per frame |
| cfg_pattern | input | 4 | Fixed pattern code |
| cfg_18bit | input | 1 | 18-bit colour depth mask |
| cfg_invert | input | 1 | Global bit inversion |
| cfg_scroll_en | input | 1 | Auto-scroll enable |
| cfg_scroll_len | input | LEN_W | Number of list entries in use (0 to 16) |
| cfg_scroll_list | input | LIST_N*4 | Packed pattern list, entry i at bits [4i+3:4i] |
| out_de | output | 1 | Delayed data-enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_r | output | 8 | Red channel |
| out_g | output | 8 | Green channel |
| out_b | output | 8 | Blue channel |

## Verification
The ramp tests use a frame height and a line width whose span does not divide 255 evenly. A stepper that rounds its step, or that drops the fractional carry, then drifts below floor(index*255/(span-1)) on middle pixels and misses 255 on the last one. A one-pixel line is also driven, where a careless zero-span guard would keep incrementing. Inverted 18-bit frames catch a design that inverts before masking, because it shows zeros in the low bits. Inverted frames also catch one that inverts blanking, because nonzero RGB then appears while data-enable is low. Scroll runs pass the last list entry, lists of length 0 and 1, and a duplicated code. They expose a design that advances on every sync cycle, wraps one entry late, or fails to restart from entry 0 after auto-scroll is re-enabled.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;

    localparam int CODE_W = 4;
    localparam int LVL_W  = 8;

    typedef logic [CODE_W-1:0] pat_code_t;
    typedef logic [LVL_W-1:0]  level_t;

    // Pattern codes (R2, R3, R4)
    localparam pat_code_t PAT_BLACK   = 4'd0;
    localparam pat_code_t PAT_WHITE   = 4'd1;
    localparam pat_code_t PAT_RED     = 4'd2;
    localparam pat_code_t PAT_GREEN   = 4'd3;
    localparam pat_code_t PAT_BLUE    = 4'd4;
    localparam pat_code_t PAT_V_GRAY  = 4'd5;
    localparam pat_code_t PAT_V_RED   = 4'd6;
    localparam pat_code_t PAT_V_GREEN = 4'd7;
    localparam pat_code_t PAT_V_BLUE  = 4'd8;
    localparam pat_code_t PAT_H_GRAY  = 4'd9;
    localparam pat_code_t PAT_H_RED   = 4'd10;
    localparam pat_code_t PAT_H_GREEN = 4'd11;
    localparam pat_code_t PAT_H_BLUE  = 4'd12;

    typedef struct packed {
        logic [LVL_W-1:0] r;
        logic [LVL_W-1:0] g;
        logic [LVL_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } sync_t;

    // Drive the selected channels {r,g,b} at one level
    function automatic rgb_t tint(logic [2:0] chan, level_t lvl);
        rgb_t p;
        p.r = chan[2] ? lvl : '0;
        p.g = chan[1] ? lvl : '0;
        p.b = chan[0] ? lvl : '0;
        return p;
    endfunction

    function automatic rgb_t pattern_pixel(pat_code_t code, level_t hlvl, level_t vlvl);
        rgb_t p;
        case (code)
            PAT_WHITE:   p = tint(3'b111, '1);
            PAT_RED:     p = tint(3'b100, '1);
            PAT_GREEN:   p = tint(3'b010, '1);
            PAT_BLUE:    p = tint(3'b001, '1);
            PAT_V_GRAY:  p = tint(3'b111, vlvl);
            PAT_V_RED:   p = tint(3'b100, vlvl);
            PAT_V_GREEN: p = tint(3'b010, vlvl);
            PAT_V_BLUE:  p = tint(3'b001, vlvl);
            PAT_H_GRAY:  p = tint(3'b111, hlvl);
            PAT_H_RED:   p = tint(3'b100, hlvl);
            PAT_H_GREEN: p = tint(3'b010, hlvl);
            PAT_H_BLUE:  p = tint(3'b001, hlvl);
            default:     p = '0;
        endcase
        return p;
    endfunction

    // 18-bit depth: keep the six upper bits of each channel
    function automatic rgb_t depth_mask(rgb_t p, logic reduced);
        rgb_t m;
        m = p;
        if (reduced) begin
            m.r[1:0] = 2'b00;
            m.g[1:0] = 2'b00;
            m.b[1:0] = 2'b00;
        end
        return m;
    endfunction

    function automatic rgb_t flip_bits(rgb_t p, logic inv);
        return inv ? ~p : p;
    endfunction

endpackage

// File: rtl/tpg_recip_div.sv
`timescale 1ns/1ps
// Serial restoring divider: computes (2**Q_W - 1) / den and its remainder.
module tpg_recip_div #(
    parameter int DEN_W = 12,
    parameter int Q_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DEN_W-1:0] den_in,
    output logic [Q_W-1:0]   quo,
    output logic [DEN_W-1:0] rem,
    output logic [DEN_W-1:0] den
);
    localparam int CNT_W = $clog2(Q_W + 1);

    logic [Q_W-1:0]   num_sr;
    logic [CNT_W-1:0] left;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {rem, num_sr[Q_W-1]};
        diff  = trial - {1'b0, den};
        fits  = (trial >= {1'b0, den});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo    <= '0;
            rem    <= '0;
            den    <= '0;
            num_sr <= '0;
            left   <= '0;
        end else if (start) begin
            den    <= den_in;
            quo    <= '0;
            rem    <= '0;
            num_sr <= '1;
            left   <= (den_in == '0) ? '0 : CNT_W'(Q_W);
        end else if (left != '0) begin
            num_sr <= num_sr << 1;
            quo    <= {quo[Q_W-2:0], fits};
            rem    <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            left   <= left - 1'b1;
        end
    end
endmodule

// File: rtl/tpg_ramp_step.sv
`timescale 1ns/1ps
// Exact floor(index * 255 / d) tracker: add the integer step each advance,
// carry one extra when the fractional accumulator reaches d.
module tpg_ramp_step #(
    parameter int DEN_W = 12,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [LVL_W-1:0] q,
    input  logic [DEN_W-1:0] r,
    input  logic [DEN_W-1:0] d,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W+1:0] LVL_MAX = {2'b00, {LVL_W{1'b1}}};

    logic [DEN_W-1:0] frac;
    logic [DEN_W:0]   frac_sum;
    logic [DEN_W:0]   frac_wrap;
    logic             carry;
    logic [LVL_W+1:0] next_lvl;

    always_comb begin
        frac_sum  = {1'b0, frac} + {1'b0, r};
        frac_wrap = frac_sum - {1'b0, d};
        carry     = (d != '0) && (frac_sum >= {1'b0, d});
        next_lvl  = {2'b00, level} + {2'b00, q} + {{(LVL_W+1){1'b0}}, carry};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            level <= '0;
            frac  <= '0;
        end else if (advance) begin
            level <= (next_lvl > LVL_MAX) ? '1 : next_lvl[LVL_W-1:0];
            frac  <= carry ? frac_wrap[DEN_W-1:0] : frac_sum[DEN_W-1:0];
        end
    end
endmodule

// File: rtl/tpg_playlist.sv
`timescale 1ns/1ps
// Auto-scroll list walker (R9, R10, R11)
module tpg_playlist #(
    parameter int LIST_N = 16,
    parameter int CODE_W = 4,
    parameter int LEN_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_start,
    input  logic                     enable,
    input  logic [LEN_W-1:0]         len,
    input  logic [LIST_N*CODE_W-1:0] list,
    input  logic [CODE_W-1:0]        fixed_code,
    output logic [CODE_W-1:0]        code,
    output logic [IDX_W-1:0]         idx
);
    logic [CODE_W-1:0] entries [LIST_N];
    logic [LEN_W-1:0]  idx_inc;
    logic              wrap;

    for (genvar i = 0; i < LIST_N; i++) begin : g_entry
        assign entries[i] = list[i*CODE_W +: CODE_W];
    end

    always_comb begin
        idx_inc = LEN_W'(idx) + LEN_W'(1);
        wrap    = (idx_inc >= len);
        code    = enable ? entries[idx] : fixed_code;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            idx <= '0;
        end else if (frame_start) begin
            idx <= wrap ? '0 : idx_inc[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/tpg_pixel_out.sv
`timescale 1ns/1ps
// Second pipeline stage: colour, depth mask, inversion, blanking (R5, R6, R7)
module tpg_pixel_out
    import tpg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sync_t     sync_in,
    input  pat_code_t code,
    input  level_t    hlvl,
    input  level_t    vlvl,
    input  logic      reduced,
    input  logic      invert,
    output sync_t     sync_out,
    output rgb_t      pix_out
);
    rgb_t raw_pix;
    rgb_t final_pix;

    always_comb begin
        raw_pix   = pattern_pixel(code, hlvl, vlvl);
        final_pix = flip_bits(depth_mask(raw_pix, reduced), invert);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_out <= '0;
            pix_out  <= '0;
        end else begin
            sync_out <= sync_in;
            pix_out  <= sync_in.de ? final_pix : '0;
        end
    end
endmodule

// File: rtl/tpg_top.sv
`timescale 1ns/1ps
module tpg_top
    import tpg_pkg::*;
#(
    parameter  int DIM_W  = 12,
    parameter  int LIST_N = 16,
    localparam int LEN_W  = $clog2(LIST_N + 1),
    localparam int IDX_W  = $clog2(LIST_N)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vid_de,
    input  logic                     vid_hs,
    input  logic                     vid_vs,
    input  logic [DIM_W-1:0]         act_width,
    input  logic [DIM_W-1:0]         act_height,
    input  logic [CODE_W-1:0]        cfg_pattern,
    input  logic                     cfg_18bit,
    input  logic                     cfg_invert,
    input  logic                     cfg_scroll_en,
    input  logic [LEN_W-1:0]         cfg_scroll_len,
    input  logic [LIST_N*CODE_W-1:0] cfg_scroll_list,
    output logic                     out_de,
    output logic                     out_hs,
    output logic                     out_vs,
    output logic [LVL_W-1:0]         out_r,
    output logic [LVL_W-1:0]         out_g,
    output logic [LVL_W-1:0]         out_b
);
    localparam int AXES   = 2;   // 0 horizontal, 1 vertical
    localparam int AX_HOR = 0;
    localparam int AX_VER = 1;

    logic       vs_d, de_d;
    logic       frame_start, line_end;
    pat_code_t  cur_code;
    logic [IDX_W-1:0] scroll_idx;

    logic [DIM_W-1:0] ax_den_in [AXES];
    logic [DIM_W-1:0] ax_rem    [AXES];
    logic [DIM_W-1:0] ax_den    [AXES];
    logic [LVL_W-1:0] ax_quo    [AXES];
    logic [LVL_W-1:0] ax_level  [AXES];
    logic             ax_clear  [AXES];
    logic             ax_adv    [AXES];

    sync_t     s1_sync;
    pat_code_t s1_code;
    level_t    s1_hlvl, s1_vlvl;
    sync_t     s2_sync;
    rgb_t      s2_pix;

    always_comb begin
        frame_start       = vid_vs & ~vs_d;
        line_end          = de_d & ~vid_de;
        ax_den_in[AX_HOR] = (act_width  == '0) ? '0 : act_width  - 1'b1;
        ax_den_in[AX_VER] = (act_height == '0) ? '0 : act_height - 1'b1;
        ax_clear[AX_HOR]  = ~vid_de;
        ax_adv[AX_HOR]    = vid_de;
        ax_clear[AX_VER]  = frame_start;
        ax_adv[AX_VER]    = line_end;
    end

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        tpg_recip_div #(.DEN_W(DIM_W), .Q_W(LVL_W)) u_div (
            .clk    (clk),
            .rst    (rst),
            .start  (frame_start),
            .den_in (ax_den_in[a]),
            .quo    (ax_quo[a]),
            .rem    (ax_rem[a]),
            .den    (ax_den[a])
        );
        tpg_ramp_step #(.DEN_W(DIM_W), .LVL_W(LVL_W)) u_step (
            .clk     (clk),
            .rst     (rst),
            .clear   (ax_clear[a]),
            .advance (ax_adv[a]),
            .q       (ax_quo[a]),
            .r       (ax_rem[a]),
            .d       (ax_den[a]),
            .level   (ax_level[a])
        );
    end

    tpg_playlist #(
        .LIST_N (LIST_N),
        .CODE_W (CODE_W),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W)
    ) u_list (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .enable      (cfg_scroll_en),
        .len         (cfg_scroll_len),
        .list        (cfg_scroll_list),
        .fixed_code  (cfg_pattern),
        .code        (cur_code),
        .idx         (scroll_idx)
    );

    // First pipeline stage
    always_ff @(posedge clk) begin
        if (rst) begin
            vs_d    <= 1'b0;
            de_d    <= 1'b0;
            s1_sync <= '0;
            s1_code <= '0;
            s1_hlvl <= '0;
            s1_vlvl <= '0;
        end else begin
            vs_d    <= vid_vs;
            de_d    <= vid_de;
            s1_sync <= {vid_de, vid_hs, vid_vs};
            s1_code <= cur_code;
            s1_hlvl <= ax_level[AX_HOR];
            s1_vlvl <= ax_level[AX_VER];
        end
    end

    tpg_pixel_out u_out (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (s1_sync),
        .code     (s1_code),
        .hlvl     (s1_hlvl),
        .vlvl     (s1_vlvl),
        .reduced  (cfg_18bit),
        .invert   (cfg_invert),
        .sync_out (s2_sync),
        .pix_out  (s2_pix)
    );

    assign out_de = s2_sync.de;
    assign out_hs = s2_sync.hs;
    assign out_vs = s2_sync.vs;
    assign out_r  = s2_pix.r;
    assign out_g  = s2_pix.g;
    assign out_b  = s2_pix.b;
endmodule

// File: rtl/tpg_checker.sv
`timescale 1ns/1ps
module tpg_checker #(
    parameter int LEN_W = 5,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             vid_de,
    input logic             vid_hs,
    input logic             vid_vs,
    input logic             cfg_18bit,
    input logic             cfg_invert,
    input logic             cfg_scroll_en,
    input logic [LEN_W-1:0] cfg_scroll_len,
    input logic             out_de,
    input logic             out_hs,
    input logic             out_vs,
    input logic [7:0]       out_r,
    input logic [7:0]       out_g,
    input logic [7:0]       out_b,
    input logic [IDX_W-1:0] scroll_idx
);
    logic       vs_q;
    logic [1:0] warm;
    logic       vs_rise;

    assign vs_rise = vid_vs & ~vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q <= 1'b0;
            warm <= '0;
        end else begin
            vs_q <= vid_vs;
            if (warm != 2'd2) warm <= warm + 1'b1;
        end
    end

    // R7
    blank_rgb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_de |-> ({out_r, out_g, out_b} == 24'h0));

    // R5
    depth_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_de && $past(cfg_18bit) && !$past(cfg_invert))
            |-> ({out_r[1:0], out_g[1:0], out_b[1:0]} == 6'b000000));

    // R6
    depth_low_inverted_chk: assert property (@(posedge clk) disable iff (rst)
        (out_de && $past(cfg_18bit) && $past(cfg_invert))
            |-> ({out_r[1:0], out_g[1:0], out_b[1:0]} == 6'b111111));

    // R8
    sync_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> ({out_de, out_hs, out_vs} == $past({vid_de, vid_hs, vid_vs}, 2)));

    // R9
    index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!vs_rise && cfg_scroll_en) |=> $stable(scroll_idx));

    // R10
    index_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (vs_rise && cfg_scroll_en && (cfg_scroll_len >= LEN_W'(2))
            && (cfg_scroll_len == LEN_W'(scroll_idx) + LEN_W'(1)))
            |=> (scroll_idx == '0));

    // R11
    index_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_scroll_en |=> (scroll_idx == '0));
endmodule

bind tpg_top tpg_checker #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .vid_de         (vid_de),
    .vid_hs         (vid_hs),
    .vid_vs         (vid_vs),
    .cfg_18bit      (cfg_18bit),
    .cfg_invert     (cfg_invert),
    .cfg_scroll_en  (cfg_scroll_en),
    .cfg_scroll_len (cfg_scroll_len),
    .out_de         (out_de),
    .out_hs         (out_hs),
    .out_vs         (out_vs),
    .out_r          (out_r),
    .out_g          (out_g),
    .out_b          (out_b),
    .scroll_idx     (scroll_idx)
);

// File: tb/tpg_top_test.sv
`timescale 1ns/1ps
module tpg_top_test;
    localparam int DIM_W  = 12;
    localparam int LIST_N = 16;
    localparam int LEN_W  = 5;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 vid_de = 1'b0, vid_hs = 1'b0, vid_vs = 1'b0;
    logic [DIM_W-1:0]     act_width = '0, act_height = '0;
    logic [3:0]           cfg_pattern = '0;
    logic                 cfg_18bit = 1'b0, cfg_invert = 1'b0, cfg_scroll_en = 1'b0;
    logic [LEN_W-1:0]     cfg_scroll_len = '0;
    logic [LIST_N*4-1:0]  cfg_scroll_list = '0;
    logic                 out_de, out_hs, out_vs;
    logic [7:0]           out_r, out_g, out_b;

    tpg_top uut (
        .clk(clk), .rst(rst), .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs),
        .act_width(act_width), .act_height(act_height), .cfg_pattern(cfg_pattern),
        .cfg_18bit(cfg_18bit), .cfg_invert(cfg_invert), .cfg_scroll_en(cfg_scroll_en),
        .cfg_scroll_len(cfg_scroll_len), .cfg_scroll_list(cfg_scroll_list),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [2:0]  syn;
        logic [23:0] pix;
        string       tag;
    } item_t;

    item_t sb[$];
    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    int    m_idx = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor: compare outputs with scoreboard items as they fall due
    always @(posedge clk) begin : monitor
        item_t it;
        #1;
        if (sb.size() > 0 && sb[0].due == cyc) begin
            it = sb.pop_front();
            check("R8", {29'd0, out_de, out_hs, out_vs}, {29'd0, it.syn});
            check(it.tag, {8'd0, out_r, out_g, out_b}, {8'd0, it.pix});
        end
    end

    // Expected pixel from the requirement text
    function automatic logic [23:0] exp_pix(int code, int x, int y, int w, int h);
        logic [7:0]  v, hl;
        logic [23:0] p;
        v  = (h > 1) ? 8'((y * 255) / (h - 1)) : 8'd0;
        hl = (w > 1) ? 8'((x * 255) / (w - 1)) : 8'd0;
        case (code)
            1:  p = 24'hFFFFFF;
            2:  p = 24'hFF0000;
            3:  p = 24'h00FF00;
            4:  p = 24'h0000FF;
            5:  p = {v, v, v};
            6:  p = {v, 8'h00, 8'h00};
            7:  p = {8'h00, v, 8'h00};
            8:  p = {8'h00, 8'h00, v};
            9:  p = {hl, hl, hl};
            10: p = {hl, 8'h00, 8'h00};
            11: p = {8'h00, hl, 8'h00};
            12: p = {8'h00, 8'h00, hl};
            default: p = 24'h000000;
        endcase
        if (cfg_18bit)  p = p & 24'hFCFCFC;
        if (cfg_invert) p = ~p;
        return p;
    endfunction

    // Driver: one input cycle, expected result queued two clocks later
    task automatic put(bit de, bit hs, bit vs, logic [23:0] pix, string tag);
        item_t it;
        @(negedge clk);
        vid_de = de;
        vid_hs = hs;
        vid_vs = vs;
        it.due = cyc + 2;
        it.syn = {de, hs, vs};
        it.pix = de ? pix : 24'h0;
        it.tag = de ? tag : "R7";
        sb.push_back(it);
    endtask

    task automatic frame(int w, int h, string tag);
        int code;
        act_width  = DIM_W'(w);
        act_height = DIM_W'(h);
        if (cfg_scroll_en) begin
            if (cfg_scroll_len <= 1 || m_idx + 1 >= int'(cfg_scroll_len)) m_idx = 0;
            else m_idx = m_idx + 1;
        end else begin
            m_idx = 0;
        end
        code = cfg_scroll_en ? int'(cfg_scroll_list[m_idx*4 +: 4]) : int'(cfg_pattern);
        for (int k = 0; k < 2; k++) put(0, 0, 1, 24'h0, "R7");
        for (int k = 0; k < 16; k++) put(0, 0, 0, 24'h0, "R7");
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) put(1, 0, 0, exp_pix(code, x, y, w, h), tag);
            for (int k = 0; k < 4; k++) put(0, (k == 1 || k == 2), 0, 24'h0, "R7");
        end
        for (int k = 0; k < 4; k++) put(0, 0, 0, 24'h0, "R7");
    endtask

    task automatic drain();
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // entry 0 green, 1 red, 2 red (duplicate), 3 horizontal gray, rest white
        for (int i = 0; i < LIST_N; i++) cfg_scroll_list[i*4 +: 4] = 4'd1;
        cfg_scroll_list[3:0]   = 4'd3;
        cfg_scroll_list[7:4]   = 4'd2;
        cfg_scroll_list[11:8]  = 4'd2;
        cfg_scroll_list[15:12] = 4'd9;

        // R1: reset holds outputs at zero even with active inputs
        rst = 1'b1;
        vid_de = 1'b1; vid_hs = 1'b1; vid_vs = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", {29'd0, out_de, out_hs, out_vs}, 32'd0);
        check("R1", {8'd0, out_r, out_g, out_b}, 32'd0);
        vid_de = 1'b0; vid_hs = 1'b0; vid_vs = 1'b0;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {29'd0, out_de, out_hs, out_vs}, 32'd0);
        check("R1", {8'd0, out_r, out_g, out_b}, 32'd0);

        // R2: solid colours and unused codes
        for (int c = 0; c < 5; c++) begin
            cfg_pattern = 4'(c);
            frame(4, 2, "R2");
            drain();
        end
        cfg_pattern = 4'd13;
        frame(4, 2, "R2");
        drain();

        // R3: vertical ramps, exact and non-exact spans
        cfg_pattern = 4'd5; frame(8, 6, "R3"); drain();
        cfg_pattern = 4'd6; frame(3, 7, "R3"); drain();
        cfg_pattern = 4'd8; frame(4, 10, "R3"); drain();
        cfg_pattern = 4'd7; frame(2, 1, "R3"); drain();

        // R4: horizontal ramps, including a one-pixel line
        cfg_pattern = 4'd9;  frame(7, 2, "R4"); drain();
        cfg_pattern = 4'd12; frame(12, 2, "R4"); drain();
        cfg_pattern = 4'd11; frame(18, 1, "R4"); drain();
        cfg_pattern = 4'd10; frame(1, 2, "R4"); drain();

        // R5: 18-bit depth
        cfg_18bit = 1'b1;
        cfg_pattern = 4'd5; frame(8, 6, "R5"); drain();
        cfg_pattern = 4'd1; frame(4, 2, "R5"); drain();

        // R6: inversion, then inversion after the mask
        cfg_18bit = 1'b0; cfg_invert = 1'b1;
        cfg_pattern = 4'd2; frame(4, 2, "R6"); drain();
        cfg_pattern = 4'd7; frame(3, 6, "R6"); drain();
        cfg_18bit = 1'b1;
        cfg_pattern = 4'd9; frame(7, 2, "R6"); drain();
        cfg_18bit = 1'b0; cfg_invert = 1'b0;
        drain();

        // R9: list order with duplicates, one entry per frame
        cfg_pattern = 4'd4;
        cfg_scroll_len = 5'd3;
        cfg_scroll_en = 1'b1;
        m_idx = 0;
        for (int f = 0; f < 5; f++) begin
            frame(4, 2, "R9");
            drain();
        end
        cfg_scroll_len = 5'd4;
        for (int f = 0; f < 3; f++) begin
            frame(5, 2, "R9");
            drain();
        end

        // R10: short lists hold entry 0
        cfg_scroll_len = 5'd1;
        for (int f = 0; f < 2; f++) begin
            frame(4, 2, "R10");
            drain();
        end
        cfg_scroll_len = 5'd0;
        frame(4, 2, "R10");
        drain();

        // R11: scroll off uses the fixed code, restart from entry 0
        cfg_scroll_en = 1'b0;
        m_idx = 0;
        frame(4, 2, "R11");
        drain();
        cfg_scroll_len = 5'd3;
        cfg_scroll_en = 1'b1;
        frame(4, 2, "R11");
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule